// File: doc/BRIEF.md
# Instruction-to-decoder steering logic

This block sits between the instruction window and a row of three decoders. Every cycle it looks at the three oldest instructions in the window. Each one carries a present bit and a complex/simple mark. It decides how many of them can be decoded this cycle and which decoder each one goes to. Only decoder 0 can decode a complex instruction. Decoders 1 and 2 take simple instructions only.

The issue decision and the number of instructions taken are combinational, so the fetch side can advance its window in the same cycle. The decoder assignment is registered and reaches the decoders one cycle later. A second register stage records, for each program position, which decoder holds that instruction. This lets the decoded results be queued in strict program order, whatever routing was used.

In every vector, bit k (or field k) belongs to slot k, and slot 0 is the oldest instruction.

Top module: `dsteer_top`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `dec_vld` and `ord_vld` are all zero.
- R2: `take_cnt` is combinational and equals the length of the longest run of present slots, starting at slot 0, that contains at most one complex instruction.
- R3: With three present simple instructions, all three issue and decoder d receives slot d.
- R4: When exactly one of the issued instructions is complex, it goes to decoder 0. The issued simple instructions go to decoders 1, 2, … in program order. So simple,simple,complex, simple,complex,simple and complex,simple,simple each issue three instructions.
- R5: Simple,complex,complex and complex,simple,complex issue two instructions, on decoders 0 and 1. Complex,complex,simple and complex,complex,complex issue only slot 0, on decoder 0.
- R6: An absent slot ends the issue group. Later present slots are not issued in that cycle, and the count never includes them.
- R7: One cycle after the decision, `dec_vld` bits 0..n-1 are set for n issued instructions. Field d of `dec_slot` (bits 2d+1:2d) holds the slot routed to decoder d. Fields of unused decoders are zero.
- R8: Two cycles after the decision, `ord_vld` bits 0..n-1 are set. Field k of `ord_dec` (bits 2k+1:2k) holds the decoder that received slot k. Unused fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_vld | input | 3 | Slot present bits, bit 0 oldest |
| slot_cplx | input | 3 | Slot complex marks |
| take_cnt | output | 2 | Instructions consumed this cycle (0 to 3) |
| dec_vld | output | 3 | Decoder input valid, registered |
| dec_slot | output | 6 | Slot index per decoder, 2 bits each |
| ord_vld | output | 3 | Program-position valid, registered twice |
| ord_dec | output | 6 | Decoder index per program position, 2 bits each |

## Verification
`take_cnt` is due in the same cycle as the inputs. The bench checks it a short delay after it drives the inputs on the falling edge. `dec_vld` and `dec_slot` are due one rising edge later, and `ord_vld` and `ord_dec` are due two rising edges later. The reference model keeps a two-deep history of its own predictions and compares each output against the matching history entry on every falling edge. All 64 input combinations are driven in sequence, and then random patterns, so every pattern class meets every pipeline stage.

// File: rtl/dsteer_pkg.sv
// Package: shared sizes for the decoder steering logic.
// Assumes one complex-capable decoder, which is always decoder 0.
package dsteer_pkg;
    localparam int NSLOT = 3;                        // window slots = decoders
    localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;   // slot/decoder index width
    localparam int CW    = $clog2(NSLOT + 1);        // issue count width
endpackage

// File: rtl/dsteer_count.sv
// Module: dsteer_count
// Decides how many leading window slots issue this cycle.
// A group ends at the first absent slot, or at a second complex instruction.
// Purely combinational.
module dsteer_count #(
    parameter int N  = 3,
    parameter int CW = 2
) (
    input  logic [N-1:0]  vld,
    input  logic [N-1:0]  cplx,
    output logic [CW-1:0] cnt,
    output logic [N-1:0]  issue
);
    logic stop;
    logic seen;

    // walk the slots oldest first and grow the issue group
    always_comb begin
        stop  = 1'b0;
        seen  = 1'b0;
        cnt   = '0;
        issue = '0;
        for (int k = 0; k < N; k++) begin
            if (!stop) begin
                if (!vld[k] || (cplx[k] && seen)) begin
                    stop = 1'b1;
                end else begin
                    issue[k] = 1'b1;
                    seen     = seen | cplx[k];
                    cnt      = cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dsteer_map.sv
// Module: dsteer_map
// Routes issued slots onto decoders.
// The complex slot, if any, goes to decoder 0. Simple slots fill the
// remaining decoders in program order.
// Assumes `issue` is a prefix mask holding at most one complex slot.
module dsteer_map #(
    parameter int N  = 3,
    parameter int SW = 2
) (
    input  logic [N-1:0]    issue,
    input  logic [N-1:0]    cplx,
    output logic [N-1:0]    dvld,
    output logic [N*SW-1:0] dec_slot,
    output logic [N*SW-1:0] slot_dec
);
    logic has_c;
    int   nxt;
    int   d;

    // compute the forward map (slot to decoder) and the inverse map
    always_comb begin
        has_c    = |(issue & cplx);
        nxt      = has_c ? 1 : 0;
        d        = 0;
        dvld     = '0;
        dec_slot = '0;
        slot_dec = '0;
        for (int k = 0; k < N; k++) begin
            if (issue[k]) begin
                if (cplx[k]) begin
                    d = 0;
                end else begin
                    d   = nxt;
                    nxt = nxt + 1;
                end
                if (d < N) begin
                    dvld[d]               = 1'b1;
                    dec_slot[d*SW +: SW]  = SW'(k);
                    slot_dec[k*SW +: SW]  = SW'(d);
                end
            end
        end
    end
endmodule

// File: rtl/dsteer_top.sv
// Module: dsteer_top
// Steers the three oldest window instructions onto three decoders.
// The consumed count is combinational. The decoder assignment is registered
// once, and the program-order record is registered a second time.
// Assumes the fetch side advances its window by take_cnt each cycle.
module dsteer_top
    import dsteer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSLOT-1:0]    slot_vld,
    input  logic [NSLOT-1:0]    slot_cplx,
    output logic [CW-1:0]       take_cnt,
    output logic [NSLOT-1:0]    dec_vld,
    output logic [NSLOT*SW-1:0] dec_slot,
    output logic [NSLOT-1:0]    ord_vld,
    output logic [NSLOT*SW-1:0] ord_dec
);
    logic [NSLOT-1:0]    issue_c;
    logic [NSLOT-1:0]    dvld_c;
    logic [NSLOT*SW-1:0] dslot_c;
    logic [NSLOT*SW-1:0] sdec_c;
    logic [NSLOT-1:0]    issue_q;
    logic [NSLOT*SW-1:0] sdec_q;

    dsteer_count #(.N(NSLOT), .CW(CW)) u_cnt (
        .vld   (slot_vld),
        .cplx  (slot_cplx),
        .cnt   (take_cnt),
        .issue (issue_c)
    );

    dsteer_map #(.N(NSLOT), .SW(SW)) u_map (
        .issue    (issue_c),
        .cplx     (slot_cplx),
        .dvld     (dvld_c),
        .dec_slot (dslot_c),
        .slot_dec (sdec_c)
    );

    // decoder stage: present the routed instructions to the decoders
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld  <= '0;
            dec_slot <= '0;
            issue_q  <= '0;
            sdec_q   <= '0;
        end else begin
            dec_vld  <= dvld_c;
            dec_slot <= dslot_c;
            issue_q  <= issue_c;
            sdec_q   <= sdec_c;
        end
    end

    // ordering stage: record the decoder of each program position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ord_vld <= '0;
            ord_dec <= '0;
        end else begin
            ord_vld <= issue_q;
            ord_dec <= sdec_q;
        end
    end

    // R2
    full_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cnt == CW'(NSLOT)) |-> ($countones(slot_cplx) <= 1));

    // R7
    dec_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_vld & (dec_vld + 1'b1)) == '0));

    // R7
    dec_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(dec_vld) == int'($past(take_cnt))));

    // R8
    ord_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ord_vld == $past(dec_vld)));

    // R4
    for (genvar k = 0; k < NSLOT; k++) begin : g_cchk
        cplx_dec0_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_vld[k] && slot_cplx[k] && (int'(take_cnt) > k))
            |=> (dec_vld[0] && (dec_slot[SW-1:0] == SW'(k))));
    end
endmodule

// File: tb/sim_dsteer_top.sv
module sim_dsteer_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] slot_vld = '0;
    logic [2:0] slot_cplx = '0;
    logic [1:0] take_cnt;
    logic [2:0] dec_vld;
    logic [5:0] dec_slot;
    logic [2:0] ord_vld;
    logic [5:0] ord_dec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // history of predictions: index 1 = one edge ago, index 2 = two edges ago
    int h_cnt  [1:2];
    int h_sdec [1:2][3];
    string h_tag [1:2];

    always #10 clk = ~clk;

    dsteer_top u0 (
        .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_cplx(slot_cplx),
        .take_cnt(take_cnt), .dec_vld(dec_vld), .dec_slot(dec_slot),
        .ord_vld(ord_vld), .ord_dec(ord_dec)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural model: collect the issued group, then hand out decoders
    task automatic model(input logic [2:0] v, input logic [2:0] c,
                         output int n, output int sdec[3], output string tag);
        int grp[$];
        int ncx = 0;
        int nextd;
        bit gap = 0;
        for (int k = 0; k < 3; k++) begin
            if (!v[k]) gap = 1;
            else if (!gap) begin
                if (c[k] && ncx == 1) gap = 1;
                else begin grp.push_back(k); if (c[k]) ncx++; end
            end
        end
        n = grp.size();
        nextd = (ncx == 1) ? 1 : 0;
        for (int k = 0; k < 3; k++) sdec[k] = 0;
        foreach (grp[i]) begin
            if (c[grp[i]]) sdec[grp[i]] = 0;
            else begin sdec[grp[i]] = nextd; nextd++; end
        end
        if (v != 3'b111 && v != 3'b011 && v != 3'b001 && v != 3'b000) tag = "R6";
        else if (v == 3'b111 && c == 3'b000) tag = "R3";
        else if ($countones(c & v) >= 2) tag = "R5";
        else tag = "R4";
    endtask

    task automatic check_pipe();
        int exp_dvld, exp_dslot, exp_ovld, exp_odec;
        exp_dvld = (1 << h_cnt[1]) - 1;
        exp_dslot = 0;
        for (int k = 0; k < h_cnt[1]; k++)
            exp_dslot |= k << (2 * h_sdec[1][k]);
        exp_ovld = (1 << h_cnt[2]) - 1;
        exp_odec = 0;
        for (int k = 0; k < h_cnt[2]; k++)
            exp_odec |= h_sdec[2][k] << (2 * k);
        chk({"R7 dec_vld ", h_tag[1]}, int'(dec_vld), exp_dvld);
        chk({"R7 dec_slot ", h_tag[1]}, int'(dec_slot), exp_dslot);
        chk({"R8 ord_vld ", h_tag[2]}, int'(ord_vld), exp_ovld);
        chk({"R8 ord_dec ", h_tag[2]}, int'(ord_dec), exp_odec);
    endtask

    task automatic step(input logic [2:0] v, input logic [2:0] c);
        int n;
        int sd[3];
        string tg;
        @(negedge clk);
        check_pipe();
        h_cnt[2] = h_cnt[1]; h_sdec[2] = h_sdec[1]; h_tag[2] = h_tag[1];
        slot_vld = v;
        slot_cplx = c;
        model(v, c, n, sd, tg);
        #1;
        chk({"R2 take_cnt ", tg}, int'(take_cnt), n);
        h_cnt[1] = n; h_sdec[1] = sd; h_tag[1] = tg;
    endtask

    initial begin
        for (int i = 1; i <= 2; i++) begin
            h_cnt[i] = 0; h_tag[i] = "R1";
            for (int k = 0; k < 3; k++) h_sdec[i][k] = 0;
        end
        slot_vld = 3'b111; slot_cplx = 3'b000;
        repeat (3) @(negedge clk);
        chk("R1 dec_vld in reset", int'(dec_vld), 0);
        chk("R1 ord_vld in reset", int'(ord_vld), 0);
        slot_vld = 3'b000;
        rst_n = 1'b1;
        // named patterns with every slot present
        step(3'b111, 3'b000);  // R3
        step(3'b111, 3'b100);  // R4 simple,simple,complex
        step(3'b111, 3'b010);  // R4 simple,complex,simple
        step(3'b111, 3'b001);  // R4 complex,simple,simple
        step(3'b111, 3'b110);  // R5 simple,complex,complex
        step(3'b111, 3'b101);  // R5 complex,simple,complex
        step(3'b111, 3'b011);  // R5 complex,complex,simple
        step(3'b111, 3'b111);  // R5 complex,complex,complex
        step(3'b101, 3'b000);  // R6 gap at slot 1
        step(3'b110, 3'b000);  // R6 slot 0 absent
        for (int p = 0; p < 64; p++) step(3'(p), 3'(p >> 3));
        for (int i = 0; i < 300; i++) step(3'($urandom), 3'($urandom));
        step(3'b000, 3'b000);
        step(3'b000, 3'b000);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule